// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This unit sits between the register file of a 32-bit core and a word-wide data memory port. For each memory operation it forms the effective address from a base register and a signed 16-bit displacement, presents the word-aligned address to memory and checks natural alignment. On loads it selects and extends the addressed byte or halfword from the returned word. For the unaligned left and right word loads it merges memory bytes into the old register value instead. On stores it builds a lane-replicated write word with a byte-enable mask.

The memory read port is assumed to return data in the same cycle the address is presented. Plain loads and plain stores finish in one cycle. The left and right partial-word stores are read-modify-write operations. The request cycle reads the aligned word, and the merged word is written in the following cycle while `busy` is high. A request offered while `busy` is high is ignored. An endian input selects how the low address bits map onto byte lanes and how the partial-word shift index is formed.

Top module: `lsu_align`

## Requirements
- R1: The effective address is `base` plus `offset` sign-extended to 32 bits. `mem_addr` is that address with bits 1:0 cleared. The `op` encoding is 0 signed byte load, 1 unsigned byte load, 2 signed halfword load, 3 unsigned halfword load, 4 word load, 5 left load, 6 right load, 7 byte store, 8 halfword store, 9 word store, 10 left store, 11 right store.
- R2: Byte loads take byte lane L of `mem_rdata`, meaning bits 8L+7:8L. L equals address bits 1:0 in little-endian mode (`big_endian`=0) and 3 minus them in big-endian mode. The signed form sign-extends the byte and the unsigned form zero-extends it.
- R3: Halfword loads take bits 31:16 when address bit 1 XOR `big_endian` is 1, and bits 15:0 otherwise. They sign-extend or zero-extend the value. Halfword loads and stores flag `addr_err` when address bit 0 is 1.
- R4: Word loads and word stores flag `addr_err` when address bits 1:0 are nonzero. A word load returns `mem_rdata` unchanged.
- R5: While `addr_err` is high, `wb_en` is 0 and `mem_we` is 0.
- R6: Left and right operations never flag `addr_err`. The shift index s is address bits 1:0. For left operations s is XORed with 3 in little-endian mode, and for right operations it is XORed with 3 in big-endian mode.
- R7: The left load returns memory bits 31 down to 8s in the same positions, with the register's lower 8s bits kept.
- R8: The right load places memory bits 31 down to 8s into result bits 31-8s down to 0, with the register's upper 8s bits kept.
- R9: A byte store drives `mem_we` with a single bit at lane L (as in R2) and replicates `rt_old[7:0]` into all four lanes. A halfword store drives `mem_we` 4'b1100 or 4'b0011, choosing the upper pair as R3 selects it for loads, and replicates `rt_old[15:0]` into both halves.
- R10: An aligned word store drives `mem_we` 4'b1111 with `mem_wdata` equal to `rt_old`.
- R11: The left and right stores assert `mem_re` with `mem_we` 0 in the request cycle. In the next cycle `busy` is 1, `mem_we` is 4'b1111, `mem_addr` holds the aligned address, and the merged word is written. For the left store, register bits 31 down to 8s go into memory bits 31-8s down to 0. For the right store, register bits 31 down to 8s replace memory bits 31 down to 8s. All other bits come from the word read.
- R12: A request while `busy` is 1 has no effect: `wb_en`, `mem_re`, `rsvd_err` and `addr_err` stay 0 and no new write is started.
- R13: Op codes 12 to 15, the doubleword and 64-bit linked/conditional forms, raise `rsvd_err` for one cycle with `wb_en` and `mem_we` at 0.
- R14: After reset, `busy` is 0 and with no request `mem_we`, `wb_en` and `mem_re` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Operation request this cycle |
| op | input | 4 | Operation code (see R1) |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| rt_old | input | 32 | Current value of the data register |
| big_endian | input | 1 | 1 selects big-endian lane mapping |
| mem_rdata | input | 32 | Word returned by memory in the same cycle |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 4 | Byte write strobes |
| mem_wdata | output | 32 | Memory write word |
| wb_en | output | 1 | Register writeback enable |
| wb_data | output | 32 | Register writeback value |
| addr_err | output | 1 | Alignment error |
| rsvd_err | output | 1 | Reserved operation |
| busy | output | 1 | Write phase of a read-modify-write store |

## Verification
The hardest state to reach is the write phase of a partial-word store that has a second request competing for the port. The stimulus issues a left or right store and, one cycle later, presents a load or a reserved op while `busy` is high. This shows that the held merged word reaches memory and that the competing request leaves no trace on writeback, read or error outputs. The merge arithmetic for both endian modes is driven by a vector table. It uses fixed register and memory words whose bytes are all distinct, so any wrong shift or mask shows in the result.

// File: rtl/lsu_align_pkg.sv
// Package: operation codes and classification helpers for the alignment unit.
// Assumes a 4-bit operation field; codes 12..15 are reserved operations.
package lsu_align_pkg;

    typedef enum logic [3:0] {
        OP_LDB  = 4'd0,
        OP_LDBU = 4'd1,
        OP_LDH  = 4'd2,
        OP_LDHU = 4'd3,
        OP_LDW  = 4'd4,
        OP_LDL  = 4'd5,
        OP_LDR  = 4'd6,
        OP_STB  = 4'd7,
        OP_STH  = 4'd8,
        OP_STW  = 4'd9,
        OP_STL  = 4'd10,
        OP_STR  = 4'd11,
        OP_RSV0 = 4'd12,
        OP_RSV1 = 4'd13,
        OP_RSV2 = 4'd14,
        OP_RSV3 = 4'd15
    } lsu_op_e;

    function automatic logic op_is_load(lsu_op_e o);
        return (o <= OP_LDR);
    endfunction

    function automatic logic op_is_plain_store(lsu_op_e o);
        return (o == OP_STB) || (o == OP_STH) || (o == OP_STW);
    endfunction

    function automatic logic op_is_rmw(lsu_op_e o);
        return (o == OP_STL) || (o == OP_STR);
    endfunction

    function automatic logic op_is_reserved(lsu_op_e o);
        return (o >= OP_RSV0);
    endfunction

    function automatic logic op_is_left(lsu_op_e o);
        return (o == OP_LDL) || (o == OP_STL);
    endfunction

    function automatic logic op_is_right(lsu_op_e o);
        return (o == OP_LDR) || (o == OP_STR);
    endfunction

    function automatic logic op_is_half(lsu_op_e o);
        return (o == OP_LDH) || (o == OP_LDHU) || (o == OP_STH);
    endfunction

    function automatic logic op_is_word(lsu_op_e o);
        return (o == OP_LDW) || (o == OP_STW);
    endfunction

endpackage

// File: rtl/lsu_agen.sv
// Address generator: adds the sign-extended displacement to the base,
// clears the low bits for the word address, checks natural alignment and
// derives the byte lane, halfword select and partial-word shift index.
// Assumes DATA_W = 32 (four byte lanes).
module lsu_agen
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16
) (
    input  lsu_op_e            op,
    input  logic [DATA_W-1:0]  base,
    input  logic [OFF_W-1:0]   offset,
    input  logic               big_endian,
    output logic [DATA_W-1:0]  word_addr,
    output logic               misaligned,
    output logic [1:0]         byte_lane,
    output logic               half_hi,
    output logic [1:0]         shift_idx
);
    logic [DATA_W-1:0] ea;
    logic [1:0]        lo;

    // Effective address and its word-aligned form.
    always_comb begin
        ea        = base + {{(DATA_W-OFF_W){offset[OFF_W-1]}}, offset};
        lo        = ea[1:0];
        word_addr = {ea[DATA_W-1:2], 2'b00};
    end

    // Natural alignment check for halfword and word accesses only.
    always_comb begin
        misaligned = (op_is_half(op) && lo[0]) ||
                     (op_is_word(op) && (lo != 2'b00));
    end

    // Lane selection according to endian mode.
    always_comb begin
        byte_lane = big_endian ? ~lo : lo;
        half_hi   = lo[1] ^ big_endian;
    end

    // Shift index for left/right partial-word operations.
    always_comb begin
        if (op_is_left(op))
            shift_idx = lo ^ (big_endian ? 2'b00 : 2'b11);
        else if (op_is_right(op))
            shift_idx = lo ^ (big_endian ? 2'b11 : 2'b00);
        else
            shift_idx = 2'b00;
    end
endmodule

// File: rtl/lsu_load_align.sv
// Load aligner: extracts and extends bytes or halfwords from the memory
// word and forms the left/right merges with the old register value.
// Assumes DATA_W = 32 and memory data valid in the request cycle.
module lsu_load_align
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  lsu_op_e            op,
    input  logic [DATA_W-1:0]  mem_word,
    input  logic [DATA_W-1:0]  reg_old,
    input  logic [1:0]         byte_lane,
    input  logic               half_hi,
    input  logic [1:0]         shift_idx,
    output logic [DATA_W-1:0]  result
);
    localparam int HALF_W = DATA_W / 2;

    logic [4:0]        sh;
    logic [DATA_W-1:0] mask_hi;
    logic [DATA_W-1:0] mask_lo;
    logic [DATA_W-1:0] lane_word;
    logic [7:0]        bval;
    logic [HALF_W-1:0] hval;

    // Field extraction and merge masks.
    always_comb begin
        sh        = {shift_idx, 3'b000};
        mask_hi   = {DATA_W{1'b1}} << sh;
        mask_lo   = {DATA_W{1'b1}} >> sh;
        lane_word = mem_word >> {byte_lane, 3'b000};
        bval      = lane_word[7:0];
        hval      = half_hi ? mem_word[DATA_W-1:HALF_W] : mem_word[HALF_W-1:0];
    end

    // Result selection per load kind.
    always_comb begin
        unique case (op)
            OP_LDB:  result = {{(DATA_W-8){bval[7]}}, bval};
            OP_LDBU: result = {{(DATA_W-8){1'b0}}, bval};
            OP_LDH:  result = {{HALF_W{hval[HALF_W-1]}}, hval};
            OP_LDHU: result = {{HALF_W{1'b0}}, hval};
            OP_LDW:  result = mem_word;
            OP_LDL:  result = (mem_word & mask_hi) | (reg_old & ~mask_hi);
            OP_LDR:  result = ((mem_word >> sh) & mask_lo) | (reg_old & ~mask_lo);
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/lsu_store_build.sv
// Store builder: replicates store data across lanes, forms the byte-enable
// mask, and computes the merged word for left/right read-modify-write stores.
// Assumes DATA_W = 32 (four byte lanes, two halfword lanes).
module lsu_store_build
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  lsu_op_e                op,
    input  logic [DATA_W-1:0]      reg_val,
    input  logic [DATA_W-1:0]      mem_word,
    input  logic [1:0]             byte_lane,
    input  logic                   half_hi,
    input  logic [1:0]             shift_idx,
    output logic [DATA_W-1:0]      st_data,
    output logic [DATA_W/8-1:0]    st_mask,
    output logic [DATA_W-1:0]      merged
);
    localparam int BYTES  = DATA_W / 8;
    localparam int HALVES = 2;
    localparam int HALF_W = DATA_W / 2;
    localparam int HBYTES = BYTES / 2;

    logic [DATA_W-1:0] rep_b;
    logic [DATA_W-1:0] rep_h;
    logic [4:0]        sh;
    logic [DATA_W-1:0] mask_hi;
    logic [DATA_W-1:0] mask_lo;

    // Replicate the low byte into every byte lane.
    for (genvar g = 0; g < BYTES; g++) begin : g_rep_byte
        assign rep_b[8*g +: 8] = reg_val[7:0];
    end

    // Replicate the low halfword into every halfword lane.
    for (genvar h = 0; h < HALVES; h++) begin : g_rep_half
        assign rep_h[HALF_W*h +: HALF_W] = reg_val[HALF_W-1:0];
    end

    // Write data and strobe per store kind.
    always_comb begin
        unique case (op)
            OP_STB: begin
                st_data = rep_b;
                st_mask = BYTES'(1) << byte_lane;
            end
            OP_STH: begin
                st_data = rep_h;
                st_mask = {{HBYTES{half_hi}}, {HBYTES{~half_hi}}};
            end
            OP_STW: begin
                st_data = reg_val;
                st_mask = {BYTES{1'b1}};
            end
            default: begin
                st_data = reg_val;
                st_mask = '0;
            end
        endcase
    end

    // Merge of register bytes into the word read for left/right stores.
    always_comb begin
        sh      = {shift_idx, 3'b000};
        mask_hi = {DATA_W{1'b1}} << sh;
        mask_lo = {DATA_W{1'b1}} >> sh;
        if (op == OP_STL)
            merged = ((reg_val >> sh) & mask_lo) | (mem_word & ~mask_lo);
        else
            merged = (reg_val & mask_hi) | (mem_word & ~mask_hi);
    end
endmodule

// File: rtl/lsu_align.sv
// Top of the load/store alignment unit. Combines the address generator,
// load aligner and store builder, and sequences the two-cycle
// read-modify-write for left/right stores. Assumes a memory port whose read
// data is valid in the same cycle as the address; requests are ignored
// while the write phase is in progress.
module lsu_align
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [3:0]           op,
    input  logic [DATA_W-1:0]    base,
    input  logic [OFF_W-1:0]     offset,
    input  logic [DATA_W-1:0]    rt_old,
    input  logic                 big_endian,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [DATA_W-1:0]    mem_addr,
    output logic                 mem_re,
    output logic [DATA_W/8-1:0]  mem_we,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic                 wb_en,
    output logic [DATA_W-1:0]    wb_data,
    output logic                 addr_err,
    output logic                 rsvd_err,
    output logic                 busy
);
    localparam int BYTES = DATA_W / 8;

    lsu_op_e             op_e;
    logic [DATA_W-1:0]   word_addr;
    logic                misaligned;
    logic [1:0]          byte_lane;
    logic                half_hi;
    logic [1:0]          shift_idx;
    logic [DATA_W-1:0]   ld_result;
    logic [DATA_W-1:0]   st_data;
    logic [BYTES-1:0]    st_mask;
    logic [DATA_W-1:0]   merged;
    logic                accept;
    logic                busy_q;
    logic [DATA_W-1:0]   wr_addr_q;
    logic [DATA_W-1:0]   wr_data_q;

    assign op_e = lsu_op_e'(op);

    lsu_agen #(.DATA_W(DATA_W), .OFF_W(OFF_W)) i_agen (
        .op         (op_e),
        .base       (base),
        .offset     (offset),
        .big_endian (big_endian),
        .word_addr  (word_addr),
        .misaligned (misaligned),
        .byte_lane  (byte_lane),
        .half_hi    (half_hi),
        .shift_idx  (shift_idx)
    );

    lsu_load_align #(.DATA_W(DATA_W)) i_load (
        .op        (op_e),
        .mem_word  (mem_rdata),
        .reg_old   (rt_old),
        .byte_lane (byte_lane),
        .half_hi   (half_hi),
        .shift_idx (shift_idx),
        .result    (ld_result)
    );

    lsu_store_build #(.DATA_W(DATA_W)) i_store (
        .op        (op_e),
        .reg_val   (rt_old),
        .mem_word  (mem_rdata),
        .byte_lane (byte_lane),
        .half_hi   (half_hi),
        .shift_idx (shift_idx),
        .st_data   (st_data),
        .st_mask   (st_mask),
        .merged    (merged)
    );

    // A request is taken only outside the write phase.
    assign accept = req_valid && !busy_q;

    // Capture the merged word and address for the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else if (accept && op_is_rmw(op_e)) begin
            busy_q    <= 1'b1;
            wr_addr_q <= word_addr;
            wr_data_q <= merged;
        end else begin
            busy_q    <= 1'b0;
        end
    end

    // Port drive: held write in the write phase, else the current request.
    always_comb begin
        addr_err = accept && misaligned;
        rsvd_err = accept && op_is_reserved(op_e);
        wb_data  = ld_result;
        wb_en    = accept && op_is_load(op_e) && !misaligned;
        busy     = busy_q;
        if (busy_q) begin
            mem_addr  = wr_addr_q;
            mem_wdata = wr_data_q;
            mem_we    = {BYTES{1'b1}};
            mem_re    = 1'b0;
        end else begin
            mem_addr  = word_addr;
            mem_wdata = st_data;
            mem_we    = (accept && op_is_plain_store(op_e) && !misaligned) ? st_mask : '0;
            mem_re    = accept && (op_is_load(op_e) || op_is_rmw(op_e)) && !misaligned;
        end
    end

    // R5
    err_blocks_effects_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (!wb_en && mem_we == '0));

    // R11
    rmw_write_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && op_is_rmw(op_e)) |=> (busy && mem_we == {BYTES{1'b1}}));

    // R11
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R12
    busy_ignores_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!wb_en && !rsvd_err && !mem_re && !addr_err));

    // R1
    addr_word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[1:0] == 2'b00);

    // R6
    partial_never_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_is_left(op_e) || op_is_right(op_e)) |-> !addr_err);

    // R9
    strobe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(mem_we) != 3) && !(mem_re && mem_we != '0));
endmodule

// File: tb/test_lsu_align.sv
module test_lsu_align;
    import lsu_align_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] base = '0;
    logic [15:0] offset = '0;
    logic [31:0] rt_old = 32'h1122_3344;
    logic        big_endian = 1'b0;
    logic [31:0] mem_rdata = 32'h8899_AABB;
    logic [31:0] mem_addr;
    logic        mem_re;
    logic [3:0]  mem_we;
    logic [31:0] mem_wdata;
    logic        wb_en;
    logic [31:0] wb_data;
    logic        addr_err;
    logic        rsvd_err;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    lsu_align i_lsu_align (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
        .base(base), .offset(offset), .rt_old(rt_old), .big_endian(big_endian),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .wb_en(wb_en),
        .wb_data(wb_data), .addr_err(addr_err), .rsvd_err(rsvd_err), .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] base;
        logic [15:0] off;
        logic        be;
        logic [31:0] addr;
        logic        err;
        logic        rsvd;
        logic        wbe;
        logic [31:0] wb;
        logic [3:0]  we;
        logic [31:0] wd;
    } vec_t;

    // rt_old = 11223344, mem_rdata = 8899AABB for every row
    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 32'h1000, 16'h0001, 1'b0, 32'h1000, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFAA, 4'h0, 32'h0}, // R2 LE lane1
        '{4'd0, 32'h1000, 16'h0001, 1'b1, 32'h1000, 1'b0, 1'b0, 1'b1, 32'hFFFF_FF99, 4'h0, 32'h0}, // R2 BE lane2
        '{4'd1, 32'h1000, 16'h0003, 1'b0, 32'h1000, 1'b0, 1'b0, 1'b1, 32'h0000_0088, 4'h0, 32'h0}, // R2 unsigned
        '{4'd2, 32'h1000, 16'hFFFE, 1'b0, 32'h0FFC, 1'b0, 1'b0, 1'b1, 32'hFFFF_8899, 4'h0, 32'h0}, // R1 R3 neg offset
        '{4'd3, 32'h1000, 16'h0002, 1'b1, 32'h1000, 1'b0, 1'b0, 1'b1, 32'h0000_AABB, 4'h0, 32'h0}, // R3 BE low half
        '{4'd2, 32'h1000, 16'h0001, 1'b0, 32'h1000, 1'b1, 1'b0, 1'b0, 32'h0,         4'h0, 32'h0}, // R3 R5 misaligned
        '{4'd4, 32'h1000, 16'h0000, 1'b0, 32'h1000, 1'b0, 1'b0, 1'b1, 32'h8899_AABB, 4'h0, 32'h0}, // R4 word
        '{4'd4, 32'h1000, 16'h0002, 1'b0, 32'h1000, 1'b1, 1'b0, 1'b0, 32'h0,         4'h0, 32'h0}, // R4 R5 misaligned
        '{4'd5, 32'h1000, 16'h0001, 1'b0, 32'h1000, 1'b0, 1'b0, 1'b1, 32'h8899_3344, 4'h0, 32'h0}, // R6 R7 LE s=2
        '{4'd5, 32'h1000, 16'h0001, 1'b1, 32'h1000, 1'b0, 1'b0, 1'b1, 32'h8899_AA44, 4'h0, 32'h0}, // R6 R7 BE s=1
        '{4'd6, 32'h1000, 16'h0001, 1'b0, 32'h1000, 1'b0, 1'b0, 1'b1, 32'h1188_99AA, 4'h0, 32'h0}, // R8 LE s=1
        '{4'd6, 32'h1000, 16'h0003, 1'b1, 32'h1000, 1'b0, 1'b0, 1'b1, 32'h8899_AABB, 4'h0, 32'h0}, // R8 BE s=0
        '{4'd7, 32'h1000, 16'h0002, 1'b0, 32'h1000, 1'b0, 1'b0, 1'b0, 32'h0,         4'h4, 32'h4444_4444}, // R9 LE byte
        '{4'd7, 32'h1000, 16'h0002, 1'b1, 32'h1000, 1'b0, 1'b0, 1'b0, 32'h0,         4'h2, 32'h4444_4444}, // R9 BE byte
        '{4'd8, 32'h1000, 16'h0002, 1'b0, 32'h1000, 1'b0, 1'b0, 1'b0, 32'h0,         4'hC, 32'h3344_3344}, // R9 LE half
        '{4'd8, 32'h1000, 16'h0000, 1'b1, 32'h1000, 1'b0, 1'b0, 1'b0, 32'h0,         4'hC, 32'h3344_3344}, // R9 BE half
        '{4'd8, 32'h1000, 16'h0003, 1'b0, 32'h1000, 1'b1, 1'b0, 1'b0, 32'h0,         4'h0, 32'h0}, // R3 R5 half store
        '{4'd9, 32'h1000, 16'h0004, 1'b0, 32'h1004, 1'b0, 1'b0, 1'b0, 32'h0,         4'hF, 32'h1122_3344}, // R10
        '{4'd9, 32'h1000, 16'h0001, 1'b0, 32'h1000, 1'b1, 1'b0, 1'b0, 32'h0,         4'h0, 32'h0}, // R4 R5 word store
        '{4'd12, 32'h1000, 16'h0000, 1'b0, 32'h1000, 1'b0, 1'b1, 1'b0, 32'h0,        4'h0, 32'h0}  // R13 reserved
    };

    task automatic drive(input logic [3:0] o, input logic [31:0] b, input logic [15:0] f, input logic e);
        @(negedge clk);
        req_valid = 1'b1; op = o; base = b; offset = f; big_endian = e;
        #2;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #2;
        // R14 reset state
        chk("R14 busy", {31'b0, busy}, 32'h0);
        chk("R14 mem_we", {28'b0, mem_we}, 32'h0);
        chk("R14 wb_en", {31'b0, wb_en}, 32'h0);
        chk("R14 mem_re", {31'b0, mem_re}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].base, VECS[i].off, VECS[i].be);
            chk($sformatf("R1 addr v%0d", i), mem_addr, VECS[i].addr);
            chk($sformatf("R4/R5 addr_err v%0d", i), {31'b0, addr_err}, {31'b0, VECS[i].err});
            chk($sformatf("R13 rsvd v%0d", i), {31'b0, rsvd_err}, {31'b0, VECS[i].rsvd});
            chk($sformatf("R5 wb_en v%0d", i), {31'b0, wb_en}, {31'b0, VECS[i].wbe});
            chk($sformatf("R5/R9 mem_we v%0d", i), {28'b0, mem_we}, {28'b0, VECS[i].we});
            if (VECS[i].wbe)
                chk($sformatf("R2/R7/R8 wb_data v%0d", i), wb_data, VECS[i].wb);
            if (VECS[i].we != 4'h0)
                chk($sformatf("R9/R10 wdata v%0d", i), mem_wdata, VECS[i].wd);
        end

        // R11 left store, little-endian, s=2: expect 88991122
        drive(4'd10, 32'h1000, 16'h0001, 1'b0);
        chk("R11 rd mem_re", {31'b0, mem_re}, 32'h1);
        chk("R11 rd mem_we", {28'b0, mem_we}, 32'h0);
        chk("R11 rd busy", {31'b0, busy}, 32'h0);
        // R12 competing load during write phase
        drive(4'd4, 32'h2000, 16'h0000, 1'b0);
        chk("R11 wr busy", {31'b0, busy}, 32'h1);
        chk("R11 wr mem_we", {28'b0, mem_we}, 32'hF);
        chk("R11 wr addr", mem_addr, 32'h1000);
        chk("R11 wr data", mem_wdata, 32'h8899_1122);
        chk("R12 wb_en", {31'b0, wb_en}, 32'h0);
        chk("R12 mem_re", {31'b0, mem_re}, 32'h0);
        @(negedge clk); req_valid = 1'b0; #2;
        chk("R11 busy drops", {31'b0, busy}, 32'h0);
        chk("R12 no new write", {28'b0, mem_we}, 32'h0);

        // R11 right store, big-endian, s=1: expect 112233BB
        drive(4'd11, 32'h1000, 16'h0002, 1'b1);
        chk("R11 R6 no err", {31'b0, addr_err}, 32'h0);
        // R12 reserved op during write phase
        drive(4'd13, 32'h3000, 16'h0000, 1'b0);
        chk("R11 wr data right", mem_wdata, 32'h1122_33BB);
        chk("R11 wr addr right", mem_addr, 32'h1000);
        chk("R12 rsvd ignored", {31'b0, rsvd_err}, 32'h0);
        @(negedge clk); req_valid = 1'b0; #2;
        chk("R12 idle after", {31'b0, busy}, 32'h0);

        // R14 reset during write phase
        drive(4'd10, 32'h1000, 16'h0000, 1'b0);
        @(negedge clk); req_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #2;
        chk("R14 busy after reset", {31'b0, busy}, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule